// File: doc/BRIEF.md
# Counting and Tracking ADC Controller

This block is the digital side of a counter-ramp or servo-tracking analog-to-digital converter. It drives an n-bit code into an external DAC. It reads back one comparator bit that is high when the analog input lies above the DAC output. The comparator and the DAC sit outside the block.

In ramp mode, a start request clears the code. The code then climbs by one per clock for as long as the comparator reports that the input is still above the DAC. The conversion ends when the comparator drops or the code reaches full scale. The code reached at that point is latched as the result, and a one-cycle done pulse is raised. Conversion time therefore grows with the input level.

In tracking mode, the code moves one step toward the input on every clock and follows a slowly varying signal. A hold input freezes the code, so the block can act as a long-term sample-and-hold. Two inhibit inputs disable one direction of the counter each. With upward steps blocked, the code settles at the lowest level the input reached over the interval. With downward steps blocked, it settles at the highest.

Top module: `ramp_track_adc_ctrl`

## Requirements
- R1: After reset, dac_code_o, result_o, busy_o and eoc_o are all 0.
- R2: With mode_i=0 and busy_o=0, a clock edge with start_i=1 sets dac_code_o to 0 and busy_o to 1.
- R3: While busy_o=1 and mode_i=0, each clock edge with cmp_i=1 and dac_code_o below 2^WIDTH-1 increases dac_code_o by exactly one.
- R4: While busy_o=1, the first edge with cmp_i=0 ends the conversion. busy_o falls, eoc_o is 1 for exactly one cycle, result_o equals the held dac_code_o, and for an input level v the pulse follows the start edge by v+1 clocks.
- R5: A full-scale input ends the conversion once dac_code_o reaches 2^WIDTH-1 with cmp_i still 1. result_o is 2^WIDTH-1 and the pulse follows the start edge by 2^WIDTH clocks.
- R6: start_i is ignored while busy_o=1. The code is not cleared and the conversion time is unchanged.
- R7: With mode_i=1 and hold_i=0, each edge moves dac_code_o up by one when cmp_i=1 and down by one when cmp_i=0. result_o equals dac_code_o, so a steady input v>0 leaves the code dithering between v-1 and v.
- R8: With mode_i=1 and hold_i=1, dac_code_o does not change, whatever cmp_i does.
- R9: With mode_i=1 and no_up_i=1, the code never rises. It settles at one below the minimum input level seen, or at 0.
- R10: With mode_i=1 and no_down_i=1, the code never falls. It settles at the maximum input level seen.
- R11: The code saturates at 0 and at 2^WIDTH-1 and never wraps.
- R12: Raising mode_i during a conversion aborts it. busy_o falls on the next edge and no eoc_o pulse is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 0 = single ramp conversion, 1 = continuous tracking |
| start_i | input | 1 | Ramp conversion request |
| cmp_i | input | 1 | Comparator: 1 when the analog input is above the DAC output |
| hold_i | input | 1 | Tracking: freeze the code |
| no_up_i | input | 1 | Tracking: block upward steps (minimum capture) |
| no_down_i | input | 1 | Tracking: block downward steps (maximum capture) |
| dac_code_o | output | WIDTH | Code to the external DAC |
| result_o | output | WIDTH | Latched ramp result, or the live code in tracking mode |
| busy_o | output | 1 | Ramp conversion in progress |
| eoc_o | output | 1 | One-cycle end-of-conversion pulse |

## Verification
A wrong counter state shows on dac_code_o at the next clock. The bench's comparator model feeds it back, so a wrong step also changes the length of the ramp. A ramp conversion that ends at the wrong step shows within one cycle of the expected instant: the eoc_o pulse comes at the wrong count, or result_o differs from the input level. A sequencer stuck busy, or one that restarts on an ignored start, shows as a wrong done-pulse delay measured from the start edge. Errors in tracking, hold and min/max capture show in the final code after a settling window of a few hundred clocks. The per-step assertions catch a bad direction or a wrap in the same cycle.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;
  typedef enum logic [1:0] {
    CNT_KEEP  = 2'd0,
    CNT_CLEAR = 2'd1,
    CNT_UP    = 2'd2,
    CNT_DOWN  = 2'd3
  } cnt_op_e;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_CONV = 1'b1
  } seq_state_e;
endpackage

// File: rtl/adc_step_counter.sv
module adc_step_counter
  import adc_ctrl_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  cnt_op_e          op_i,
  output logic [WIDTH-1:0] code_o,
  output logic             at_max_o,
  output logic             at_min_o
);
  localparam logic [WIDTH-1:0] CODE_MAX = {WIDTH{1'b1}};

  logic [WIDTH-1:0] code_q, code_d;

  assign at_max_o = (code_q == CODE_MAX);
  assign at_min_o = (code_q == '0);

  // saturating: full scale and zero are sticky in their own direction
  always_comb begin
    code_d = code_q;
    unique case (op_i)
      CNT_CLEAR: code_d = '0;
      CNT_UP:    if (!at_max_o) code_d = code_q + 1'b1;
      CNT_DOWN:  if (!at_min_o) code_d = code_q - 1'b1;
      default:   code_d = code_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) code_q <= '0;
    else         code_q <= code_d;
  end

  assign code_o = code_q;
endmodule

// File: rtl/adc_ramp_seq.sv
module adc_ramp_seq
  import adc_ctrl_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             start_i,
  input  logic             cmp_i,
  input  logic             at_max_i,
  input  logic [WIDTH-1:0] code_i,
  output cnt_op_e          op_o,
  output logic             busy_o,
  output logic             eoc_o,
  output logic [WIDTH-1:0] result_o
);
  seq_state_e       state_q, state_d;
  logic             eoc_q, eoc_d;
  logic [WIDTH-1:0] result_q, result_d;

  always_comb begin
    state_d  = state_q;
    eoc_d    = 1'b0;
    result_d = result_q;
    op_o     = CNT_KEEP;
    unique case (state_q)
      SEQ_IDLE: begin
        if (enable_i && start_i) begin
          state_d = SEQ_CONV;
          op_o    = CNT_CLEAR;
        end
      end
      SEQ_CONV: begin
        if (!enable_i) begin
          state_d = SEQ_IDLE;            // aborted, no done pulse
        end else if (cmp_i && !at_max_i) begin
          op_o = CNT_UP;
        end else begin
          state_d  = SEQ_IDLE;
          eoc_d    = 1'b1;
          result_d = code_i;
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= SEQ_IDLE;
      eoc_q    <= 1'b0;
      result_q <= '0;
    end else begin
      state_q  <= state_d;
      eoc_q    <= eoc_d;
      result_q <= result_d;
    end
  end

  assign busy_o   = (state_q == SEQ_CONV);
  assign eoc_o    = eoc_q;
  assign result_o = result_q;
endmodule

// File: rtl/adc_track_dir.sv
module adc_track_dir
  import adc_ctrl_pkg::*;
(
  input  logic    hold_i,
  input  logic    cmp_i,
  input  logic    no_up_i,
  input  logic    no_down_i,
  output cnt_op_e op_o
);
  always_comb begin
    op_o = CNT_KEEP;
    if (!hold_i) begin
      if (cmp_i && !no_up_i)        op_o = CNT_UP;
      else if (!cmp_i && !no_down_i) op_o = CNT_DOWN;
    end
  end
endmodule

// File: rtl/ramp_track_adc_ctrl.sv
module ramp_track_adc_ctrl
  import adc_ctrl_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_i,
  input  logic             start_i,
  input  logic             cmp_i,
  input  logic             hold_i,
  input  logic             no_up_i,
  input  logic             no_down_i,
  output logic [WIDTH-1:0] dac_code_o,
  output logic [WIDTH-1:0] result_o,
  output logic             busy_o,
  output logic             eoc_o
);
  cnt_op_e          ramp_op, track_op, cnt_op;
  logic [WIDTH-1:0] code, ramp_result;
  logic             at_max, at_min;

  adc_step_counter #(.WIDTH(WIDTH)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .op_i     (cnt_op),
    .code_o   (code),
    .at_max_o (at_max),
    .at_min_o (at_min)
  );

  adc_ramp_seq #(.WIDTH(WIDTH)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .enable_i (!mode_i),
    .start_i  (start_i),
    .cmp_i    (cmp_i),
    .at_max_i (at_max),
    .code_i   (code),
    .op_o     (ramp_op),
    .busy_o   (busy_o),
    .eoc_o    (eoc_o),
    .result_o (ramp_result)
  );

  adc_track_dir u_dir (
    .hold_i    (hold_i),
    .cmp_i     (cmp_i),
    .no_up_i   (no_up_i),
    .no_down_i (no_down_i),
    .op_o      (track_op)
  );

  assign cnt_op     = mode_i ? track_op : ramp_op;
  assign dac_code_o = code;
  assign result_o   = mode_i ? code : ramp_result;
endmodule

// File: rtl/adc_ctrl_checker.sv
module adc_ctrl_checker #(
  parameter int WIDTH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mode_i,
  input logic             start_i,
  input logic             cmp_i,
  input logic             hold_i,
  input logic             no_up_i,
  input logic             no_down_i,
  input logic [WIDTH-1:0] dac_code_o,
  input logic [WIDTH-1:0] result_o,
  input logic             busy_o,
  input logic             eoc_o
);
  localparam logic [WIDTH-1:0] CODE_MAX = {WIDTH{1'b1}};

  AST_START_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_i && !busy_o && start_i) |=> (busy_o && dac_code_o == '0)); // R2
  AST_RAMP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_i && busy_o && cmp_i && dac_code_o != CODE_MAX)
      |=> (busy_o && dac_code_o == $past(dac_code_o) + 1'b1)); // R3
  AST_EOC_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoc_o |=> !eoc_o); // R4
  AST_EOC_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoc_o |-> (!busy_o && result_o == dac_code_o)); // R4
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_i && busy_o && start_i && cmp_i && dac_code_o != '0 && dac_code_o != CODE_MAX)
      |=> dac_code_o != '0); // R6
  AST_TRACK_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && !hold_i && !cmp_i && !no_down_i && dac_code_o != '0)
      |=> dac_code_o == $past(dac_code_o) - 1'b1); // R7
  AST_HOLD_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && hold_i) |=> $stable(dac_code_o)); // R8
  AST_NO_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && no_up_i) |=> dac_code_o <= $past(dac_code_o)); // R9
  AST_NO_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && no_down_i) |=> dac_code_o >= $past(dac_code_o)); // R10
  AST_NO_WRAP_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && dac_code_o == CODE_MAX) |=> dac_code_o >= CODE_MAX - 1'b1); // R11
  AST_NO_WRAP_BOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && dac_code_o == '0) |=> dac_code_o <= WIDTH'(1)); // R11
  AST_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && busy_o) |=> (!busy_o && !eoc_o)); // R12
endmodule

bind ramp_track_adc_ctrl adc_ctrl_checker #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/ramp_track_adc_ctrl_test.sv
module ramp_track_adc_ctrl_test;
  localparam int W = 8;
  localparam int MAXV = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode = 1'b0, start = 1'b0, hold = 1'b0, no_up = 1'b0, no_down = 1'b0;
  logic ovr_en = 1'b0, ovr_val = 1'b0;
  logic [W-1:0] vin = '0;
  logic [W-1:0] dac_code, result;
  logic busy, eoc, cmp;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  // analog comparator model, optionally overridden
  assign cmp = ovr_en ? ovr_val : (vin > dac_code);

  ramp_track_adc_ctrl #(.WIDTH(W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .start_i(start), .cmp_i(cmp),
    .hold_i(hold), .no_up_i(no_up), .no_down_i(no_down),
    .dac_code_o(dac_code), .result_o(result), .busy_o(busy), .eoc_o(eoc)
  );

  function automatic int exp_ramp_cycles(int v);
    return v + 1;
  endfunction

  function automatic int exp_min_code(int m);
    return (m == 0) ? 0 : m - 1;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_ramp(int v, bit glitch);
    int n;
    @(negedge clk);
    mode = 1'b0; vin = W'(v); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R2 busy after start", int'(busy), 1);
    check(dac_code == '0, "R2 code cleared", int'(dac_code), 0);
    n = 0;
    while (!eoc && n < 400) begin
      @(negedge clk);
      n++;
      if (n == 2 && v >= 2) check(dac_code == W'(2), "R3 ramp step", int'(dac_code), 2);
      if (glitch && n == 3) start = 1'b1;
      if (glitch && n == 4) start = 1'b0;
    end
    check(n == exp_ramp_cycles(v), (v == MAXV) ? "R5 full-scale time" :
          (glitch ? "R6 start ignored time" : "R4 conversion time"), n, exp_ramp_cycles(v));
    check(result == W'(v), (v == MAXV) ? "R5 full-scale result" : "R4 result", int'(result), v);
    check(busy == 1'b0, "R4 busy low at done", int'(busy), 0);
    @(negedge clk);
    check(eoc == 1'b0, "R4 single-cycle pulse", int'(eoc), 0);
  endtask

  initial begin
    int v, m;
    void'($urandom(32'd1234));
    run(3);
    check(dac_code == '0 && result == '0, "R1 reset code/result", int'(dac_code), 0);
    check(busy == 1'b0 && eoc == 1'b0, "R1 reset flags", int'(busy), 0);
    rst_n = 1'b1;
    run(2);

    // ramp: directed corners and random levels
    do_ramp(0, 0);
    do_ramp(1, 0);
    do_ramp(MAXV, 0);
    do_ramp(100, 1);
    for (int k = 0; k < 6; k++) do_ramp(int'($urandom_range(MAXV, 0)), k[0]);

    // R12: abort by mode change
    @(negedge clk);
    vin = 8'd200; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    run(10);
    mode = 1'b1;
    @(negedge clk);
    check(busy == 1'b0, "R12 abort busy", int'(busy), 0);
    begin
      bit seen;
      seen = 0;
      for (int i = 0; i < 20; i++) begin
        if (eoc) seen = 1;
        @(negedge clk);
      end
      check(!seen, "R12 no done pulse", int'(seen), 0);
    end

    // R7 tracking on random levels
    for (int k = 0; k < 5; k++) begin
      v = (k == 0) ? 0 : int'($urandom_range(MAXV, 0));
      vin = W'(v);
      run(300);
      if (v == 0) check(dac_code == '0, "R7 track zero", int'(dac_code), 0);
      else check(dac_code == W'(v) || dac_code == W'(v - 1), "R7 track level", int'(dac_code), v);
      check(result == dac_code, "R7 result follows code", int'(result), int'(dac_code));
    end

    // R8 hold
    vin = 8'd90;
    run(300);
    hold = 1'b1;
    @(negedge clk);
    v = int'(dac_code);
    vin = 8'd10;
    run(50);
    check(dac_code == W'(v), "R8 hold low input", int'(dac_code), v);
    vin = 8'd250;
    run(50);
    check(dac_code == W'(v), "R8 hold high input", int'(dac_code), v);
    hold = 1'b0;

    // R11 saturation via comparator override
    ovr_en = 1'b1; ovr_val = 1'b1;
    run(300);
    check(dac_code == W'(MAXV), "R11 saturate top", int'(dac_code), MAXV);
    ovr_val = 1'b0;
    run(300);
    check(dac_code == '0, "R11 saturate bottom", int'(dac_code), 0);

    // R9 minimum capture from full scale
    ovr_val = 1'b1;
    run(300);
    no_up = 1'b1; ovr_en = 1'b0;
    m = MAXV;
    for (int k = 0; k < 5; k++) begin
      v = int'($urandom_range(MAXV, 20));
      if (v < m) m = v;
      vin = W'(v);
      run(300);
    end
    check(dac_code == W'(exp_min_code(m)), "R9 minimum", int'(dac_code), exp_min_code(m));
    no_up = 1'b0;

    // R10 maximum capture from zero
    ovr_en = 1'b1; ovr_val = 1'b0;
    run(300);
    no_down = 1'b1; ovr_en = 1'b0;
    m = 0;
    for (int k = 0; k < 5; k++) begin
      v = int'($urandom_range(230, 0));
      if (v > m) m = v;
      vin = W'(v);
      run(300);
    end
    check(dac_code == W'(m), "R10 maximum", int'(dac_code), m);
    no_down = 1'b0;

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule